// File: doc/BRIEF.md
# Serial FIFO Threshold Flag Controller

This block produces the two threshold status flags of a buffered serial port: a transmit-space flag that says the transmit FIFO has drained to a chosen level, and a receive-level flag that says the receive FIFO has filled to a chosen level. It keeps the occupancy count of each FIFO from push and pop strobes. Each cycle it compares the counts with trigger levels chosen from small fixed tables, and it raises each flag whenever its condition holds.

A raised flag stays up until software clears it. To clear a flag, software must first read the status register while the flag is one, then write zero to that flag's bit. If the level condition still holds at the moment of the clear, the flag stays up. Each flag drives an interrupt line gated by its own enable bit, and a one-cycle DMA request strobe on every rising edge of the flag. The FIFO storage, shifters and baud logic sit outside the block and are seen only through the push and pop strobes.

Top module: `sfc_flag_ctrl`

## Requirements
- R1: Each FIFO count starts at 0. A push is accepted only when the count is below DEPTH (16), and a pop only when the count is above 0, both judged on the count before the clock edge. The count changes by the accepted pushes minus the accepted pops. Register 2 reads the transmit count and register 3 reads the receive count.
- R2: The transmit flag (status bit 0) becomes 1 on the clock edge after one where the transmit count is at or below the transmit trigger. The transmit trigger is selected by control bits [3:2]: 0 gives 8, 1 gives 4, 2 gives 2, 3 gives 1.
- R3: The receive flag (status bit 1) becomes 1 on the clock edge after one where the receive count is at or above the receive trigger. The receive trigger is selected by control bits [1:0]: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 14.
- R4: Software clears a flag by writing 0 to its bit in the status register (address 0). The clear takes effect only if a read of address 0 happened, with that flag at 1, after the flag's last clear. A write of 0 to an unarmed flag does nothing.
- R5: Writing 1 to a flag bit leaves the flag unchanged and keeps its arming. A write of 0 that clears the flag, or that tries to and loses to R6, uses up the arming, so the next clear needs a fresh read.
- R6: When a flag's set condition holds on the same edge as a valid clear, the flag stays 1.
- R7: The transmit interrupt is the transmit flag ANDed with control bit 6. The receive interrupt is the receive flag ANDed with control bit 7. Both flags keep updating while their interrupts are disabled.
- R8: Each DMA request output is high for exactly the one cycle in which its flag goes from 0 to 1.
- R9: While control bit 4 (transmit) or bit 5 (receive) is 1, that FIFO's count is forced to 0 from the next edge on, and pushes to it are ignored. A flag that is already raised stays raised until it is cleared.
- R10: After reset, both flags, both counts, the control register, both interrupts and both DMA requests are 0. The transmit flag rises on the first edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 status, 1 control, 2 transmit count, 3 receive count |
| bus_rd | input | 1 | Read strobe; a read of address 0 arms the flags that are 1 |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| tx_push | input | 1 | Byte written into transmit FIFO |
| tx_pop | input | 1 | Byte taken by the transmit shifter |
| rx_push | input | 1 | Byte delivered by the receive shifter |
| rx_pop | input | 1 | Byte read out of the receive FIFO |
| tx_count | output | 5 | Transmit FIFO occupancy |
| rx_count | output | 5 | Receive FIFO occupancy |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |
| tx_dreq | output | 1 | Transmit DMA request strobe |
| rx_dreq | output | 1 | Receive DMA request strobe |

## Verification
The bench targets the clear protocol. It writes zero without a prior read, where a design that skips the arming step would drop the flag early. It writes one before a zero, where a design that takes one as a clear would lose the flag. It retries a clear after a failed one, where a design that keeps the arming would accept a stale clear. It clears while the level condition still holds, where a design that lets the clear win would lose a request that software still owes. It also drives the counts to full and through simultaneous push and pop, where an off-by-one would pass the limit. Finally it drives a FIFO reset while a flag is up and the interrupt is masked, where a design that ties the flag to the interrupt enable would let the flag stop updating.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

   localparam logic [1:0] ADDR_STATUS = 2'd0;
   localparam logic [1:0] ADDR_CTRL   = 2'd1;
   localparam logic [1:0] ADDR_TXCNT  = 2'd2;
   localparam logic [1:0] ADDR_RXCNT  = 2'd3;

   typedef struct packed {
      logic       rx_irq_en;
      logic       tx_irq_en;
      logic       rx_flush;
      logic       tx_flush;
      logic [1:0] tx_sel;
      logic [1:0] rx_sel;
   } ctrl_t;

   // receive level table: grows with the selector
   function automatic int rx_level(input logic [1:0] sel, input int depth);
      case (sel)
         2'd0:    return 1;
         2'd1:    return depth / 4;
         2'd2:    return depth / 2;
         default: return depth - 2;
      endcase
   endfunction

   // transmit level table: shrinks with the selector
   function automatic int tx_level(input logic [1:0] sel, input int depth);
      case (sel)
         2'd0:    return depth / 2;
         2'd1:    return depth / 4;
         2'd2:    return depth / 8;
         default: return 1;
      endcase
   endfunction

endpackage

// File: rtl/sfc_level_counter.sv
module sfc_level_counter #(
   parameter int DEPTH = 16,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic          pop,
   output logic [CW-1:0] count
);
   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   logic take_in, take_out;

   assign take_in  = push & (count != FULL);
   assign take_out = pop  & (count != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (flush)
         count <= '0;
      else
         count <= count + CW'(take_in) - CW'(take_out);
   end

   a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL);

   a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0));

endmodule

// File: rtl/sfc_flag_cell.sv
module sfc_flag_cell #(
   parameter int CW    = 5,
   parameter bit IS_TX = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] count,
   input  logic [CW-1:0] level,
   input  logic          status_rd,
   input  logic          zero_wr,
   output logic          flag,
   output logic          dreq
);
   logic hit, armed, clr_ok, flag_n;

   generate
      if (IS_TX) begin : g_drain
         assign hit = (count <= level);
      end else begin : g_fill
         assign hit = (count >= level);
      end
   endgenerate

   assign clr_ok = zero_wr & armed;
   assign flag_n = hit | (flag & ~clr_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag  <= 1'b0;
         dreq  <= 1'b0;
         armed <= 1'b0;
      end else begin
         flag  <= flag_n;
         dreq  <= flag_n & ~flag;
         armed <= (status_rd & flag) | (armed & ~clr_ok);
      end
   end

   a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> flag);

   a_r4_clear_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> $past(zero_wr && armed));

   a_r8_dreq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      dreq |-> (flag && !$past(flag)));

endmodule

// File: rtl/sfc_ctrl_regs.sv
module sfc_ctrl_regs
   import sfc_pkg::*;
#(
   parameter int CW    = 5,
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       addr,
   input  logic             wr,
   input  logic [BUS_W-1:0] wdata,
   input  logic [1:0]       flags,
   input  logic [CW-1:0]    tx_cnt,
   input  logic [CW-1:0]    rx_cnt,
   output ctrl_t            ctrl,
   output logic [BUS_W-1:0] rdata
);
   localparam int PAD = BUS_W - CW;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl <= '0;
      else if (wr && addr == ADDR_CTRL)
         ctrl <= ctrl_t'(wdata[7:0]);
   end

   always_comb begin
      rdata = '0;
      case (addr)
         ADDR_STATUS: rdata[1:0] = flags;
         ADDR_CTRL:   rdata[7:0] = ctrl;
         ADDR_TXCNT:  rdata = {{PAD{1'b0}}, tx_cnt};
         default:     rdata = {{PAD{1'b0}}, rx_cnt};
      endcase
   end

endmodule

// File: rtl/sfc_flag_ctrl.sv
module sfc_flag_ctrl
   import sfc_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int BUS_W = 8,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       bus_addr,
   input  logic             bus_rd,
   input  logic             bus_wr,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   input  logic             tx_push,
   input  logic             tx_pop,
   input  logic             rx_push,
   input  logic             rx_pop,
   output logic [CW-1:0]    tx_count,
   output logic [CW-1:0]    rx_count,
   output logic             tx_irq,
   output logic             rx_irq,
   output logic             tx_dreq,
   output logic             rx_dreq
);
   localparam int NDIR = 2;

   generate
      if (DEPTH < 8 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 8");
      end
      if (BUS_W < 8 || BUS_W <= CW) begin : g_bad_bus
         $error("BUS_W must be at least 8 and wider than the count");
      end
   endgenerate

   ctrl_t             ctrl;
   logic [NDIR-1:0]   push_v, pop_v, flush_v, flag_v, dreq_v, zero_v;
   logic [CW-1:0]     cnt   [NDIR];
   logic [CW-1:0]     level [NDIR];
   logic              status_rd, status_wr;

   assign status_rd = bus_rd & (bus_addr == ADDR_STATUS);
   assign status_wr = bus_wr & (bus_addr == ADDR_STATUS);

   assign push_v  = {rx_push, tx_push};
   assign pop_v   = {rx_pop, tx_pop};
   assign flush_v = {ctrl.rx_flush, ctrl.tx_flush};
   assign level[0] = CW'(tx_level(ctrl.tx_sel, DEPTH));
   assign level[1] = CW'(rx_level(ctrl.rx_sel, DEPTH));

   genvar d;
   generate
      for (d = 0; d < NDIR; d++) begin : g_dir
         assign zero_v[d] = status_wr & ~bus_wdata[d];

         sfc_level_counter #(.DEPTH(DEPTH), .CW(CW)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .flush (flush_v[d]),
            .push  (push_v[d]),
            .pop   (pop_v[d]),
            .count (cnt[d])
         );

         sfc_flag_cell #(.CW(CW), .IS_TX(d == 0)) u_flag (
            .clk       (clk),
            .rst_n     (rst_n),
            .count     (cnt[d]),
            .level     (level[d]),
            .status_rd (status_rd),
            .zero_wr   (zero_v[d]),
            .flag      (flag_v[d]),
            .dreq      (dreq_v[d])
         );
      end
   endgenerate

   sfc_ctrl_regs #(.CW(CW), .BUS_W(BUS_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (bus_addr),
      .wr     (bus_wr),
      .wdata  (bus_wdata),
      .flags  (flag_v),
      .tx_cnt (cnt[0]),
      .rx_cnt (cnt[1]),
      .ctrl   (ctrl),
      .rdata  (bus_rdata)
   );

   assign tx_count = cnt[0];
   assign rx_count = cnt[1];
   assign tx_irq   = flag_v[0] & ctrl.tx_irq_en;
   assign rx_irq   = flag_v[1] & ctrl.rx_irq_en;
   assign tx_dreq  = dreq_v[0];
   assign rx_dreq  = dreq_v[1];

   a_r5_one_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (status_wr && bus_wdata[0] && flag_v[0]) |=> flag_v[0]);

endmodule

// File: tb/tb_sfc_flag_ctrl.sv
`timescale 1ns/1ps
module tb_sfc_flag_ctrl;
   localparam int DEPTH = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic [1:0] bus_addr = '0;
   logic       bus_rd = 1'b0, bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
   logic [4:0] tx_count, rx_count;
   logic       tx_irq, rx_irq, tx_dreq, rx_dreq;

   always #2 clk = ~clk;

   sfc_flag_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_push(tx_push), .tx_pop(tx_pop), .rx_push(rx_push), .rx_pop(rx_pop),
      .tx_count(tx_count), .rx_count(rx_count), .tx_irq(tx_irq),
      .rx_irq(rx_irq), .tx_dreq(tx_dreq), .rx_dreq(rx_dreq)
   );

   int n_chk = 0, n_bad = 0;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   int rx_tab[4] = '{1, 4, 8, 14};
   int tx_tab[4] = '{8, 4, 2, 1};
   int  m_txc, m_rxc;
   bit  m_tf, m_rf, m_arm_t, m_arm_r, m_dq_t, m_dq_r;
   bit [7:0] m_ctrl;
   bit  hs_t, hs_r, ok_t, ok_r, nt, nr;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_txc = 0; m_rxc = 0; m_tf = 0; m_rf = 0; m_arm_t = 0; m_arm_r = 0;
         m_dq_t = 0; m_dq_r = 0; m_ctrl = 0;
      end else begin
         hs_t = (m_txc <= tx_tab[m_ctrl[3:2]]);
         hs_r = (m_rxc >= rx_tab[m_ctrl[1:0]]);
         ok_t = bus_wr && bus_addr == 0 && !bus_wdata[0] && m_arm_t;
         ok_r = bus_wr && bus_addr == 0 && !bus_wdata[1] && m_arm_r;
         nt = hs_t || (m_tf && !ok_t);
         nr = hs_r || (m_rf && !ok_r);
         m_arm_t = (bus_rd && bus_addr == 0 && m_tf) || (m_arm_t && !ok_t);
         m_arm_r = (bus_rd && bus_addr == 0 && m_rf) || (m_arm_r && !ok_r);
         m_dq_t = nt && !m_tf;
         m_dq_r = nr && !m_rf;
         m_tf = nt;
         m_rf = nr;
         if (m_ctrl[4]) m_txc = 0;
         else m_txc = m_txc + ((tx_push && m_txc < DEPTH) ? 1 : 0) - ((tx_pop && m_txc > 0) ? 1 : 0);
         if (m_ctrl[5]) m_rxc = 0;
         else m_rxc = m_rxc + ((rx_push && m_rxc < DEPTH) ? 1 : 0) - ((rx_pop && m_rxc > 0) ? 1 : 0);
         if (bus_wr && bus_addr == 1) m_ctrl = bus_wdata;
      end
   end

   function automatic int exp_rdata();
      case (bus_addr)
         2'd0:    return {m_rf, m_tf};
         2'd1:    return m_ctrl;
         2'd2:    return m_txc;
         default: return m_rxc;
      endcase
   endfunction

   // every-cycle comparison, away from the active edge
   always @(negedge clk) begin
      chk("R1/R9 tx_count", tx_count, m_txc);
      chk("R1/R9 rx_count", rx_count, m_rxc);
      chk("R7 tx_irq", tx_irq, m_tf && m_ctrl[6]);
      chk("R7 rx_irq", rx_irq, m_rf && m_ctrl[7]);
      chk("R8 tx_dreq", tx_dreq, m_dq_t);
      chk("R8 rx_dreq", rx_dreq, m_dq_r);
      chk("R2/R3/R4/R5/R6 bus_rdata", bus_rdata, exp_rdata());
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick(input int n);
      repeat (n) begin @(negedge clk); #1; end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      tick(1);
      bus_wr = 1'b0;
   endtask

   task automatic rd_status();
      bus_addr = 2'd0; bus_rd = 1'b1;
      tick(1);
      bus_rd = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output int v);
      bus_addr = a; #0.2; v = bus_rdata;
   endtask

   task automatic push_tx(input int n);
      repeat (n) begin tx_push = 1'b1; tick(1); end
      tx_push = 1'b0;
   endtask
   task automatic pop_tx(input int n);
      repeat (n) begin tx_pop = 1'b1; tick(1); end
      tx_pop = 1'b0;
   endtask
   task automatic push_rx(input int n);
      repeat (n) begin rx_push = 1'b1; tick(1); end
      rx_push = 1'b0;
   endtask
   task automatic pop_rx(input int n);
      repeat (n) begin rx_pop = 1'b1; tick(1); end
      rx_pop = 1'b0;
   endtask

   task automatic run();
      int v;
      #0.5 rst_n = 1'b0;
      tick(3);
      peek(0, v);
      chk("R10 status at reset", v, 0);
      chk("R10 tx_count at reset", tx_count, 0);
      chk("R10 tx_irq at reset", tx_irq, 0);
      rst_n = 1'b1;
      tick(1);
      peek(0, v);
      chk("R10 tx flag after release", v, 1);
      chk("R8 tx_dreq pulse", tx_dreq, 1);
      tick(1);
      chk("R8 tx_dreq one cycle", tx_dreq, 0);

      wr(1, 8'hC0);
      chk("R7 tx_irq enabled", tx_irq, 1);
      chk("R7 rx_irq idle", rx_irq, 0);

      push_tx(9); tick(1);
      chk("R1 tx_count nine", tx_count, 9);
      wr(0, 8'h00);
      peek(0, v);
      chk("R4 clear without read ignored", v & 1, 1);
      rd_status();
      wr(0, 8'h01);
      peek(0, v);
      chk("R5 write one keeps flag", v & 1, 1);
      wr(0, 8'h00);
      peek(0, v);
      chk("R4 armed clear", v & 1, 0);
      chk("R4 tx_irq dropped", tx_irq, 0);

      pop_tx(1);
      tick(1);
      peek(0, v);
      chk("R2 tx flag at trigger 8", v & 1, 1);
      chk("R8 tx_dreq on re-rise", tx_dreq, 1);
      rd_status();
      wr(0, 8'h00);
      peek(0, v);
      chk("R6 set wins over clear", v & 1, 1);

      wr(1, 8'hCC);
      wr(0, 8'h00);
      peek(0, v);
      chk("R5 arming used up", v & 1, 1);
      rd_status();
      wr(0, 8'h00);
      peek(0, v);
      chk("R2 cleared above trigger 1", v & 1, 0);
      pop_tx(7);
      peek(0, v);
      chk("R2 flag still low one edge after", v & 1, 0);
      tick(1);
      peek(0, v);
      chk("R2 tx flag at trigger 1", v & 1, 1);

      wr(1, 8'hCE);
      push_rx(7); tick(1);
      peek(0, v);
      chk("R3 below rx trigger 8", (v >> 1) & 1, 0);
      push_rx(1); tick(1);
      peek(0, v);
      chk("R3 rx flag at 8", (v >> 1) & 1, 1);
      chk("R7 rx_irq up", rx_irq, 1);
      rd_status();
      wr(0, 8'h01);
      peek(0, v);
      chk("R6 rx flag stays", (v >> 1) & 1, 1);
      pop_rx(1); tick(1);
      rd_status();
      wr(0, 8'h01);
      peek(0, v);
      chk("R4 rx cleared after drain", (v >> 1) & 1, 0);
      chk("R5 tx untouched by one", v & 1, 1);

      wr(1, 8'h4E);
      push_rx(1); tick(1);
      peek(0, v);
      chk("R7 flag updates while masked", (v >> 1) & 1, 1);
      chk("R7 rx_irq masked", rx_irq, 0);

      push_rx(12);
      chk("R1 rx saturates", rx_count, 16);
      rx_push = 1'b1; rx_pop = 1'b1; tick(1);
      chk("R1 full push and pop", rx_count, 15);
      tick(1);
      rx_push = 1'b0; rx_pop = 1'b0;
      chk("R1 mid push and pop", rx_count, 15);

      wr(1, 8'h6E);
      tick(1);
      chk("R9 rx flushed", rx_count, 0);
      push_rx(2);
      chk("R9 push ignored", rx_count, 0);
      peek(0, v);
      chk("R9 raised flag held", (v >> 1) & 1, 1);
      rd_status();
      wr(0, 8'h01);
      peek(0, v);
      chk("R9 rx flag cleared", (v >> 1) & 1, 0);
      wr(1, 8'h4E);

      push_tx(5); tick(1);
      chk("R1 tx_count six", tx_count, 6);
      rd_status();
      wr(0, 8'h02);
      peek(0, v);
      chk("R4 tx cleared", v & 1, 0);
      wr(1, 8'h5E);
      tick(1);
      chk("R9 tx flushed", tx_count, 0);
      tick(1);
      peek(0, v);
      chk("R9 empty sets tx flag", v & 1, 1);

      wr(1, 8'h4F);
      push_rx(13); tick(1);
      peek(0, v);
      chk("R3 below rx trigger 14", (v >> 1) & 1, 0);
      push_rx(1); tick(1);
      peek(0, v);
      chk("R3 rx flag at 14", (v >> 1) & 1, 1);
      chk("R8 rx_dreq pulse", rx_dreq, 1);
      tick(2);
   endtask

   initial begin
      fork
         run();
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog R10 actual=hung expected=done");
         end
      join_any
      disable fork;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule